// File: doc/BRIEF.md
# Packed Integer Dot-Product Accumulator

This execution unit treats each of two 32-bit operands as a short vector of packed integers. It multiplies the elements pairwise, adds the products together and then adds a third 32-bit operand, the accumulator. A 4-bit opcode chooses the element size and the signedness. The element size is one of three: two 16-bit halves, four bytes or eight nibbles. Element pairs are matched by bit position, so element i of one operand meets element i of the other.

A clamp input chooses what happens when the true sum does not fit in 32 bits. With clamp low the result wraps. With clamp high the result saturates at the edge of the signed or unsigned 32-bit range. The saturation decision is made on the full-precision sum.

The unit is a two-stage pipeline with no handshake. The products are registered in the first stage. The second stage reduces them, adds the accumulator and clamps. One operation can be issued every cycle. Its result comes out two clock edges later, qualified by a valid flag. An opcode outside the defined set returns zero and raises an error flag.

Top module: `pdot_unit`

## Requirements
- R1: While reset is high and after it, until the first issued operation emerges, out_valid, out_err and out_result are all zero.
- R2: Opcode 4 (signed) and opcode 5 (unsigned) compute a[31:16]*b[31:16] + a[15:0]*b[15:0] + c. The signed form sign-extends the halves and the unsigned form zero-extends them.
- R3: Opcode 6 (signed) and opcode 7 (unsigned) multiply the byte pairs at bit offsets 0, 8, 16 and 24, then add the four products and c.
- R4: Opcode 8 (signed) and opcode 9 (unsigned) multiply the nibble pairs at bit offsets 0, 4, 8, 12, 16, 20, 24 and 28, then add the eight products and c.
- R5: In the signed opcodes (4, 6, 8), each element is sign-extended from its own top bit, and c is taken as a signed 32-bit value. In the unsigned opcodes (5, 7, 9), the elements and c are zero-extended.
- R6: With in_clamp low, out_result is the exact sum modulo 2^32.
- R7: With in_clamp high and a signed opcode, a sum above 2^31-1 gives 32'h7FFF_FFFF, a sum below -2^31 gives 32'h8000_0000, and any other sum is passed through unchanged.
- R8: With in_clamp high and an unsigned opcode, a sum above 2^32-1 gives 32'hFFFF_FFFF, and any other sum is passed through unchanged.
- R9: The saturation decision uses the exact sum. A product sum that overflows 32 bits but is brought back into range by c is not saturated.
- R10: An operation issued with in_valid high at clock edge n appears on the outputs after edge n+1. Operations issued on consecutive cycles each produce their own result.
- R11: A valid operation with an opcode other than 4 to 9 gives out_err = 1 and out_result = 0.
- R12: A cycle whose input had in_valid low gives out_valid = 0, out_err = 0 and out_result = 0, whatever the other inputs were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue an operation this cycle |
| in_op | input | 4 | Opcode: 4/5 dual 16-bit, 6/7 quad 8-bit, 8/9 octal 4-bit, even = signed |
| in_clamp | input | 1 | Saturate instead of wrap |
| in_a | input | 32 | First packed operand |
| in_b | input | 32 | Second packed operand |
| in_c | input | 32 | Accumulator operand |
| out_valid | output | 1 | Result qualifier, two cycles after issue |
| out_err | output | 1 | Undefined opcode was issued |
| out_result | output | 32 | Dot product plus accumulator |

## Verification
Each nibble format is swept over every pair of nibble values. The byte format is swept over every byte value. Together these sweeps catch a wrong extraction offset, and they catch sign extension taken from the wrong bit, which shows up as errors of ±16 or ±256 per element. The saturation tests are placed exactly on the edges 2^31-1, -2^31 and 2^32-1, and one step outside each. A clamp with an off-by-one comparison, or a clamp that tests only the low 32 bits, would fail at these points. One case has a product sum of 2^31 and a negative accumulator. A design that saturated on intermediate overflow would wrongly return 32'h7FFF_FFFF there. Random back-to-back streams, idle gaps and every undefined opcode check that results are neither dropped nor shifted between pipeline slots, and that bad opcodes never leak a nonzero result.

// File: rtl/pdot_pkg.sv
package pdot_pkg;

    localparam int WORD_W    = 32;
    localparam int ELEM_MAX  = 16;
    localparam int EXT_W     = ELEM_MAX + 1;
    localparam int PROD_W    = 2 * EXT_W;
    localparam int MAX_LANES = WORD_W / 4;
    localparam int SUM_W     = PROD_W + $clog2(MAX_LANES) + 2;

    typedef enum logic [3:0] {
        OP_D2S = 4'h4,
        OP_D2U = 4'h5,
        OP_D4S = 4'h6,
        OP_D4U = 4'h7,
        OP_D8S = 4'h8,
        OP_D8U = 4'h9
    } op_e;

    typedef enum logic [1:0] {
        FMT_H16 = 2'd0,
        FMT_B8  = 2'd1,
        FMT_N4  = 2'd2
    } fmt_e;

    typedef struct packed {
        logic legal;
        fmt_e fmt;
        logic sgn;
        logic clamp;
    } ctl_t;

    function automatic ctl_t decode_op(input logic [3:0] op, input logic clamp);
        ctl_t d;
        d.clamp = clamp;
        d.legal = 1'b1;
        case (op)
            OP_D2S:  begin d.fmt = FMT_H16; d.sgn = 1'b1; end
            OP_D2U:  begin d.fmt = FMT_H16; d.sgn = 1'b0; end
            OP_D4S:  begin d.fmt = FMT_B8;  d.sgn = 1'b1; end
            OP_D4U:  begin d.fmt = FMT_B8;  d.sgn = 1'b0; end
            OP_D8S:  begin d.fmt = FMT_N4;  d.sgn = 1'b1; end
            OP_D8U:  begin d.fmt = FMT_N4;  d.sgn = 1'b0; end
            default: begin d.fmt = FMT_N4;  d.sgn = 1'b0; d.legal = 1'b0; end
        endcase
        return d;
    endfunction

    // Pull element 'lane' out of a word and widen it to EXT_W bits.
    function automatic logic signed [EXT_W-1:0] elem_get(input logic [WORD_W-1:0] w,
                                                         input fmt_e f,
                                                         input int lane,
                                                         input logic sgn);
        logic [15:0] h;
        logic [7:0]  y;
        logic [3:0]  n;
        logic signed [EXT_W-1:0] e;
        e = '0;
        case (f)
            FMT_H16: if (lane < WORD_W / 16) begin
                h = w[lane*16 +: 16];
                e = {sgn & h[15], h};
            end
            FMT_B8: if (lane < WORD_W / 8) begin
                y = w[lane*8 +: 8];
                e = {{(EXT_W-8){sgn & y[7]}}, y};
            end
            default: if (lane < WORD_W / 4) begin
                n = w[lane*4 +: 4];
                e = {{(EXT_W-4){sgn & n[3]}}, n};
            end
        endcase
        return e;
    endfunction

endpackage

// File: rtl/pdot_lane.sv
module pdot_lane
    import pdot_pkg::*;
#(
    parameter int LANE = 0
) (
    input  logic [WORD_W-1:0]        a,
    input  logic [WORD_W-1:0]        b,
    input  fmt_e                     fmt,
    input  logic                     sgn,
    output logic signed [PROD_W-1:0] prod
);
    logic signed [EXT_W-1:0] ea;
    logic signed [EXT_W-1:0] eb;

    always_comb begin
        ea   = elem_get(a, fmt, LANE, sgn);
        eb   = elem_get(b, fmt, LANE, sgn);
        prod = ea * eb;
    end
endmodule

// File: rtl/pdot_reduce.sv
module pdot_reduce
    import pdot_pkg::*;
(
    input  logic signed [PROD_W-1:0] prods [MAX_LANES],
    input  logic [WORD_W-1:0]        acc_in,
    input  logic                     sgn,
    input  logic                     clamp,
    output logic [WORD_W-1:0]        result
);
    localparam logic signed [SUM_W-1:0] S_MAX = {{(SUM_W-WORD_W+1){1'b0}}, {(WORD_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] S_MIN = {{(SUM_W-WORD_W+1){1'b1}}, {(WORD_W-1){1'b0}}};
    localparam logic signed [SUM_W-1:0] U_MAX = {{(SUM_W-WORD_W){1'b0}}, {WORD_W{1'b1}}};

    logic signed [SUM_W-1:0] total;

    always_comb begin
        total = {{(SUM_W-WORD_W){sgn & acc_in[WORD_W-1]}}, acc_in};
        for (int i = 0; i < MAX_LANES; i++) begin
            total = total + {{(SUM_W-PROD_W){prods[i][PROD_W-1]}}, prods[i]};
        end
        result = total[WORD_W-1:0];
        if (clamp) begin
            if (sgn) begin
                if (total > S_MAX)      result = S_MAX[WORD_W-1:0];
                else if (total < S_MIN) result = S_MIN[WORD_W-1:0];
            end else begin
                if (total > U_MAX)      result = {WORD_W{1'b1}};
                else if (total < 0)     result = '0;
            end
        end
    end
endmodule

// File: rtl/pdot_unit.sv
module pdot_unit
    import pdot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [3:0]        in_op,
    input  logic              in_clamp,
    input  logic [WORD_W-1:0] in_a,
    input  logic [WORD_W-1:0] in_b,
    input  logic [WORD_W-1:0] in_c,
    output logic              out_valid,
    output logic              out_err,
    output logic [WORD_W-1:0] out_result
);
    ctl_t                     ctl_in;
    logic signed [PROD_W-1:0] prod_w [MAX_LANES];

    logic                     s1_vld;
    ctl_t                     s1_ctl;
    logic [WORD_W-1:0]        s1_c;
    logic signed [PROD_W-1:0] s1_prod [MAX_LANES];
    logic [WORD_W-1:0]        red_res;

    assign ctl_in = decode_op(in_op, in_clamp);

    for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
        pdot_lane #(.LANE(g)) lane_i (
            .a    (in_a),
            .b    (in_b),
            .fmt  (ctl_in.fmt),
            .sgn  (ctl_in.sgn),
            .prod (prod_w[g])
        );
    end

    // Stage 1: products and control.
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld <= 1'b0;
            s1_ctl <= '0;
            s1_c   <= '0;
            for (int i = 0; i < MAX_LANES; i++) s1_prod[i] <= '0;
        end else begin
            s1_vld <= in_valid;
            s1_ctl <= ctl_in;
            s1_c   <= in_c;
            for (int i = 0; i < MAX_LANES; i++) s1_prod[i] <= prod_w[i];
        end
    end

    pdot_reduce red_i (
        .prods  (s1_prod),
        .acc_in (s1_c),
        .sgn    (s1_ctl.sgn),
        .clamp  (s1_ctl.clamp),
        .result (red_res)
    );

    // Stage 2: reduced, accumulated, clamped result.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_err    <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid  <= s1_vld;
            out_err    <= s1_vld & ~s1_ctl.legal;
            out_result <= (s1_vld && s1_ctl.legal) ? red_res : '0;
        end
    end
endmodule

// File: rtl/pdot_unit_chk.sv
module pdot_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [3:0]  in_op,
    input logic [31:0] in_a,
    input logic [31:0] in_c,
    input logic        out_valid,
    input logic        out_err,
    input logic [31:0] out_result
);
    logic [1:0] cyc;
    logic       bad_op;

    assign bad_op = (in_op < 4'h4) || (in_op > 4'h9);

    always_ff @(posedge clk) begin
        if (rst)             cyc <= 2'd0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    p_latency_r10: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    p_err_issue_r11: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2) |-> (out_err == $past(in_valid && bad_op, 2)));

    p_err_zero_r11: assert property (@(posedge clk) disable iff (rst)
        out_err |-> (out_valid && out_result == 32'h0));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_err && out_result == 32'h0));

    p_zero_a_r6: assert property (@(posedge clk) disable iff (rst)
        ((cyc >= 2'd2) && $past(in_valid && !bad_op && in_a == 32'h0, 2))
        |-> (out_result == $past(in_c, 2)));
endmodule

bind pdot_unit pdot_unit_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_a       (in_a),
    .in_c       (in_c),
    .out_valid  (out_valid),
    .out_err    (out_err),
    .out_result (out_result)
);

// File: tb/pdot_unit_tb.sv
`timescale 1ns/1ps
module pdot_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = 4'h0;
    logic        in_clamp = 1'b0;
    logic [31:0] in_a = '0, in_b = '0, in_c = '0;
    logic        out_valid, out_err;
    logic [31:0] out_result;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic        exp_v [2];
    logic        exp_e [2];
    logic [31:0] exp_r [2];
    string       exp_t [2];

    always #2 clk = ~clk;

    pdot_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_clamp(in_clamp), .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .out_valid(out_valid), .out_err(out_err), .out_result(out_result)
    );

    function automatic void ref_calc(input int op, input bit clamp,
                                     input logic [31:0] a, input logic [31:0] b,
                                     input logic [31:0] c,
                                     output bit err, output logic [31:0] res);
        int n, wd;
        bit sg;
        longint acc, ea, eb, msk, half;
        if (op < 4 || op > 9) begin
            err = 1'b1;
            res = '0;
            return;
        end
        err = 1'b0;
        n   = (op < 6) ? 2 : (op < 8) ? 4 : 8;
        sg  = (op % 2) == 0;
        wd  = 32 / n;
        msk = (64'sd1 <<< wd) - 1;
        half = 64'sd1 <<< (wd - 1);
        acc = sg ? longint'($signed(c)) : longint'({32'b0, c});
        for (int i = 0; i < n; i++) begin
            ea = (longint'({32'b0, a}) >>> (i * wd)) & msk;
            eb = (longint'({32'b0, b}) >>> (i * wd)) & msk;
            if (sg && ea >= half) ea = ea - (msk + 1);
            if (sg && eb >= half) eb = eb - (msk + 1);
            acc = acc + ea * eb;
        end
        if (clamp) begin
            if (sg) begin
                if (acc > 64'sd2147483647)  acc = 64'sd2147483647;
                if (acc < -64'sd2147483648) acc = -64'sd2147483648;
            end else begin
                if (acc > 64'sd4294967295)  acc = 64'sd4294967295;
                if (acc < 0)                acc = 0;
            end
        end
        res = acc[31:0];
    endfunction

    task automatic compare(input string tag, input logic v, input logic e, input logic [31:0] r);
        checks++;
        if (out_valid !== v || out_err !== e || out_result !== r) begin
            errors++;
            $display("FAIL %s got v=%0b e=%0b r=%h expected v=%0b e=%0b r=%h",
                     tag, out_valid, out_err, out_result, v, e, r);
        end
    endtask

    task automatic step(input bit v, input int op, input bit clamp,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] c, input string tag);
        bit e;
        logic [31:0] r;
        @(negedge clk);
        compare(exp_t[1], exp_v[1], exp_e[1], exp_r[1]);
        exp_v[1] = exp_v[0]; exp_e[1] = exp_e[0];
        exp_r[1] = exp_r[0]; exp_t[1] = exp_t[0];
        in_valid = v; in_op = op[3:0]; in_clamp = clamp;
        in_a = a; in_b = b; in_c = c;
        if (v) begin
            ref_calc(op, clamp, a, b, c, e, r);
            exp_v[0] = 1'b1; exp_e[0] = e; exp_r[0] = r;
        end else begin
            exp_v[0] = 1'b0; exp_e[0] = 1'b0; exp_r[0] = '0;
        end
        exp_t[0] = tag;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired got running expected finished");
        finish_run();
    end

    initial begin
        logic [15:0] hv [7];
        logic [7:0]  bv [6];
        logic [31:0] cv [4];
        hv = '{16'h0000, 16'h0001, 16'h7fff, 16'h8000, 16'hffff, 16'h1234, 16'hcdef};
        cv = '{32'h0, 32'h1, 32'hffffffff, 32'h80000000};
        for (int i = 0; i < 2; i++) begin
            exp_v[i] = 0; exp_e[i] = 0; exp_r[i] = '0; exp_t[i] = "R1";
        end

        // R1: reset state with garbage inputs driven.
        in_valid = 1'b1; in_op = 4'h4; in_a = 32'hffffffff; in_b = 32'hffffffff;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1", 1'b0, 1'b0, 32'h0);
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        step(0, 0, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 0, 0, "R1");

        // R4 / R5: every nibble pair in the octal format.
        for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++)
                for (int op = 8; op <= 9; op++)
                    step(1, op, (x + y) % 2, {8{x[3:0]}},
                         {y[3:0], y[3:0] + 4'd1, y[3:0] + 4'd2, y[3:0] + 4'd3,
                          y[3:0] + 4'd4, y[3:0] + 4'd5, y[3:0] + 4'd6, y[3:0] + 4'd7},
                         cv[(x + y) % 4], "R4");

        // R3 / R5: every byte value against edge bytes in the quad format.
        bv = '{8'h00, 8'h01, 8'h7f, 8'h80, 8'hff, 8'h5a};
        for (int x = 0; x < 256; x++)
            for (int k = 0; k < 6; k++)
                for (int op = 6; op <= 7; op++)
                    step(1, op, x % 2, {x[7:0], ~x[7:0], x[7:0] ^ 8'h5a, x[7:0]},
                         {bv[k], bv[(k + 1) % 6], bv[(k + 2) % 6], bv[k] ^ x[7:0]},
                         cv[k % 4], "R3");

        // R2: half-word corner values, both signedness, both clamp settings.
        for (int p = 0; p < 7; p++)
            for (int q = 0; q < 7; q++)
                for (int op = 4; op <= 5; op++)
                    for (int cl = 0; cl < 2; cl++)
                        step(1, op, cl[0], {hv[p], hv[q]}, {hv[q], hv[(p + 3) % 7]},
                             cv[(p + q) % 4], "R2");

        // R5: top-bit sign extension of each element width.
        step(1, 8, 0, 32'h88888888, 32'h11111111, 32'h0, "R5");       // -64
        step(1, 9, 0, 32'h88888888, 32'h11111111, 32'h0, "R5");       // 64
        step(1, 6, 0, 32'h80ff0180, 32'h01010101, 32'h0, "R5");       // -128-1+1-128
        step(1, 4, 0, 32'h0000ffff, 32'h00000002, 32'hfffffff0, "R5");
        step(1, 5, 0, 32'h0000ffff, 32'h00000002, 32'hfffffff0, "R5");

        // R6: unsigned overflow wraps without clamp.
        step(1, 5, 0, 32'hffffffff, 32'hffffffff, 32'hffffffff, "R6");
        step(1, 4, 0, 32'h80008000, 32'h80008000, 32'h0, "R6");      // 2^31 -> 80000000

        // R7: signed saturation edges.
        step(1, 4, 1, 32'h80008000, 32'h80008000, 32'h0, "R7");      // 2^31 -> 7fffffff
        step(1, 4, 1, 32'h80008000, 32'h80008000, 32'hffffffff, "R7"); // exactly 2^31-1
        step(1, 4, 1, 32'h80008000, 32'h7fff7fff, 32'h80000000, "R7"); // below min
        step(1, 4, 1, 32'h00000000, 32'h00000000, 32'h80000000, "R7"); // exactly -2^31
        step(1, 4, 1, 32'h00000001, 32'h00000001, 32'h7fffffff, "R7"); // one above max

        // R8: unsigned saturation edges.
        step(1, 5, 1, 32'hffffffff, 32'hffffffff, 32'hffffffff, "R8");
        step(1, 7, 1, 32'h00000000, 32'h00000000, 32'hffffffff, "R8"); // exactly max
        step(1, 9, 1, 32'h00000001, 32'h00000001, 32'hffffffff, "R8"); // one above

        // R9: intermediate overflow pulled back into range by c.
        step(1, 4, 1, 32'h80008000, 32'h80008000, 32'hfffffffb, "R9"); // 7ffffffb
        step(1, 4, 1, 32'h80008000, 32'h7fff7fff, 32'h00010000, "R9");

        // R11: every undefined opcode, both clamp settings.
        for (int op = 0; op < 16; op++)
            if (op < 4 || op > 9)
                for (int cl = 0; cl < 2; cl++)
                    step(1, op, cl[0], 32'hffffffff, 32'h7f7f7f7f, 32'h12345678, "R11");

        // R12: idle cycles with active-looking inputs.
        step(0, 4, 1, 32'hffffffff, 32'hffffffff, 32'h1, "R12");
        step(0, 12, 0, 32'h1, 32'h1, 32'h1, "R12");
        step(0, 9, 0, 32'h5, 32'h5, 32'h5, "R12");

        // R10: random back-to-back stream with occasional gaps.
        for (int i = 0; i < 2000; i++) begin
            automatic int unsigned rv = $urandom;
            step((rv % 7) != 0, 4 + int'((rv >> 4) % 6), rv[8],
                 $urandom, $urandom, $urandom, "R10");
        end

        repeat (3) step(0, 0, 0, 0, 0, 0, "R12");
        finish_run();
    end
endmodule